// File: doc/BRIEF.md
# Variable-Length Dot Product Unit

This block computes the dot product of two short vectors of unsigned 8-bit elements, eight elements per vector. A 3-bit length input chooses how many leading element pairs are summed. A length of 5 means that pairs 0 to 4 are multiplied and the five products are added. The result is a 32-bit unsigned value.

Every element pair gets its own multiplier, and all of them work in parallel. The products feed a chain of adders. Tap k of the chain holds the sum of products 0 to k. A multiplexer driven by the length input picks one tap. The size of the hardware never depends on the run-time length value, and no loop is unrolled against a signal.

Each accumulator stage is assigned on every evaluation, so there is no feedback of stale values and no latch. A parameter selects whether the result goes through an output register, which is on by default, or leaves the block directly.

Top module: `vl_dot_product`

## Requirements
- R1: A length of 0 gives a result of 0, whatever the operand values are.
- R2: A length n in the range 1 to 7 gives the sum over i = 0 .. n-1 of vec_a element i times vec_b element i. Element i occupies bits [8*i+7 : 8*i] of its vector, and elements are read as unsigned numbers.
- R3: Each product is zero-extended to 32 bits before it is added. The result therefore never exceeds 7 x 255 x 255 = 455175, and all-ones operands produce exactly 65025 times the length.
- R4: Elements at an index equal to or above the length have no effect on the result. Element 7 is never summed, because the 3-bit length cannot reach 8.
- R5: With the output register enabled, result shows the sum for the inputs present at the previous rising clock edge.
- R6: With the output register enabled, a synchronous active-high rst clears result to 0 at the next rising edge.
- R7: Each tap of the partial-sum chain is at least as large as the tap before it. Each step adds at most one 8x8 product (65025).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| vec_a | input | 64 | First operand vector, element i at bits [8*i+7:8*i] |
| vec_b | input | 64 | Second operand vector, same layout as vec_a |
| len | input | 3 | Number of leading pairs to sum (0 to 7) |
| result | output | 32 | Unsigned dot product of the selected pairs |

## Verification
The bench builds two instances from the default sizes: eight elements of 8 bits, a 3-bit length and a 32-bit result. One instance has the output register enabled and the other has it disabled. The registered instance brings the one-cycle latency and the synchronous clear within reach. The combinational instance is compared in the same cycle its inputs change. With these sizes, the bench can sweep every length value, including 0 and the maximum of 7. It also reaches the all-ones overflow bound, and it can show that element 7 is never used, because the length field is one value short of addressing it.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  // Largest number of pairs any length code can select.
  function automatic int dp_pairs_reachable(int n_elem, int len_w);
    int top_code;
    top_code = (1 << len_w) - 1;
    return (top_code < n_elem) ? top_code : n_elem;
  endfunction

  // Largest possible product of two unsigned elements of width w.
  function automatic longint dp_max_product(int w);
    longint e;
    e = (longint'(1) << w) - 1;
    return e * e;
  endfunction

  // Worst-case sum over the reachable pairs.
  function automatic longint dp_max_sum(int n_elem, int len_w, int w);
    return longint'(dp_pairs_reachable(n_elem, len_w)) * dp_max_product(w);
  endfunction

endpackage

// File: rtl/dotp_lane.sv
module dotp_lane #(
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic [ELEM_W-1:0] op_a,
  input  logic [ELEM_W-1:0] op_b,
  output logic [ACC_W-1:0]  prod
);
  import dotp_pkg::*;

  localparam longint PROD_MAX = dp_max_product(ELEM_W);

  // Both operands widened before the multiply: no truncation of the product.
  always_comb prod = ACC_W'(op_a) * ACC_W'(op_b);

  always_comb begin
    a_r3_product_bound: assert (longint'(prod) <= PROD_MAX)
      else $error("product above element bound");
  end
endmodule

// File: rtl/dotp_chain.sv
module dotp_chain #(
  parameter int NUM_ELEM = 8,
  parameter int ACC_W    = 32
) (
  input  logic [NUM_ELEM-1:0][ACC_W-1:0] prods,
  output logic [NUM_ELEM-1:0][ACC_W-1:0] partial
);
  import dotp_pkg::*;

  // Every stage written on each evaluation: no self-reference, no latch.
  always_comb begin
    partial[0] = prods[0];
    for (int i = 1; i < NUM_ELEM; i++) begin
      partial[i] = partial[i-1] + prods[i];
    end
  end

  always_comb begin
    for (int i = 1; i < NUM_ELEM; i++) begin
      a_r7_chain_monotonic: assert ((partial[i] >= partial[i-1]) &&
                                    ((partial[i] - partial[i-1]) <= 32'd65025))
        else $error("partial-sum chain step out of range at %0d", i);
    end
  end
endmodule

// File: rtl/dotp_select.sv
module dotp_select #(
  parameter int NUM_ELEM = 8,
  parameter int LEN_W    = 3,
  parameter int ACC_W    = 32
) (
  input  logic [NUM_ELEM-1:0][ACC_W-1:0] partial,
  input  logic [LEN_W-1:0]               len,
  output logic [ACC_W-1:0]               sum_out
);
  localparam int NUM_TAPS = 1 << LEN_W;

  logic [NUM_TAPS-1:0][ACC_W-1:0] taps;

  // Tap 0 is the empty sum, tap k holds pairs 0..k-1; codes past the
  // vector length saturate at the full sum.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (k == 0) begin : g_empty
      assign taps[k] = '0;
    end else if (k <= NUM_ELEM) begin : g_chain
      assign taps[k] = partial[k-1];
    end else begin : g_sat
      assign taps[k] = partial[NUM_ELEM-1];
    end
  end

  always_comb sum_out = taps[len];
endmodule

// File: rtl/vl_dot_product.sv
module vl_dot_product #(
  parameter int NUM_ELEM   = 8,
  parameter int ELEM_W     = 8,
  parameter int LEN_W      = 3,
  parameter int ACC_W      = 32,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_ELEM*ELEM_W-1:0] vec_a,
  input  logic [NUM_ELEM*ELEM_W-1:0] vec_b,
  input  logic [LEN_W-1:0]           len,
  output logic [ACC_W-1:0]           result
);
  import dotp_pkg::*;

  localparam longint SUM_MAX = dp_max_sum(NUM_ELEM, LEN_W, ELEM_W);

  logic [NUM_ELEM-1:0][ACC_W-1:0] lane_prod;
  logic [NUM_ELEM-1:0][ACC_W-1:0] chain_sum;
  logic [ACC_W-1:0]               picked_sum;

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
    dotp_lane #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_lane (
      .op_a (vec_a[i*ELEM_W +: ELEM_W]),
      .op_b (vec_b[i*ELEM_W +: ELEM_W]),
      .prod (lane_prod[i])
    );
  end

  dotp_chain #(.NUM_ELEM(NUM_ELEM), .ACC_W(ACC_W)) u_chain (
    .prods   (lane_prod),
    .partial (chain_sum)
  );

  dotp_select #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_sel (
    .partial (chain_sum),
    .len     (len),
    .sum_out (picked_sum)
  );

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) result <= '0;
      else     result <= picked_sum;
    end

    a_r1_zero_len: assert property (@(posedge clk) disable iff (rst)
      (len == '0) |=> (result == '0))
      else $error("nonzero result for zero length");

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (longint'(result) <= SUM_MAX))
      else $error("result above worst-case sum");

    a_r6_reset_clears: assert property (@(posedge clk)
      rst |=> (result == '0))
      else $error("result not cleared by reset");

    a_r5_holds_when_idle: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $stable(vec_a) && $stable(vec_b) && $stable(len))
        |=> $stable(result))
      else $error("result moved with steady inputs");
  end else begin : g_comb
    always_comb result = picked_sum;

    always_comb begin
      a_r3_no_overflow_c: assert (longint'(result) <= SUM_MAX)
        else $error("result above worst-case sum");
    end
  end
endmodule

// File: tb/sim_vl_dot_product.sv
`timescale 1ns/1ps
module sim_vl_dot_product;
  localparam int N = 8;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N*W-1:0] vec_a = '0;
  logic [N*W-1:0] vec_b = '0;
  logic [2:0]    len = '0;
  logic [31:0]   result, result_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    longint exp;
    string  req;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  vl_dot_product u0 (.clk(clk), .rst(rst), .vec_a(vec_a), .vec_b(vec_b),
                     .len(len), .result(result));

  vl_dot_product #(.REGISTERED(1'b0)) u1 (.clk(clk), .rst(rst), .vec_a(vec_a),
                     .vec_b(vec_b), .len(len), .result(result_c));

  // Reference: walk the bytes as plain numbers, independent of any chain.
  function automatic longint ref_dot(logic [N*W-1:0] a, logic [N*W-1:0] b, int n);
    longint acc = 0;
    for (int i = 0; i < N; i++) begin
      if (i < n) acc += longint'(a[i*W +: W]) * longint'(b[i*W +: W]);
    end
    return acc;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: applies one vector at the falling edge and queues its outcome.
  task automatic drive(logic [N*W-1:0] a, logic [N*W-1:0] b, int n,
                       bit do_rst, string req);
    item_t it;
    @(negedge clk);
    vec_a = a; vec_b = b; len = 3'(n); rst = do_rst;
    it.exp = do_rst ? 0 : ref_dot(a, b, n);
    it.req = req;
    sb.push_back(it);
    #2;
    check({req, " comb"}, longint'(result_c), ref_dot(a, b, n));
  endtask

  // Monitor: one item per rising edge, compared a little after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.req, longint'(result), it.exp);
    end
  end

  function automatic logic [N*W-1:0] rnd_vec();
    return {$urandom(), $urandom()};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [N*W-1:0] a, b, t;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R6 reset state", longint'(result), 0);

    // R1 / R2: every length with random data
    for (int r = 0; r < 6; r++) begin
      for (int n = 0; n < 8; n++) begin
        drive(rnd_vec(), rnd_vec(), n, 1'b0, (n == 0) ? "R1" : "R2");
      end
    end
    // R2: length 5, known values: 1*2+2*3+3*4+4*5+5*6 = 70
    drive(64'hFF_FF_FF_05_04_03_02_01, 64'hFF_FF_FF_06_05_04_03_02, 5, 1'b0, "R2 len5");
    // R3: all-ones operands at every length
    for (int n = 0; n < 8; n++) begin
      drive({N*W{1'b1}}, {N*W{1'b1}}, n, 1'b0, "R3 all-ones");
    end
    // R4: tails beyond the length must not matter
    for (int n = 0; n < 8; n++) begin
      a = rnd_vec(); b = rnd_vec();
      t = rnd_vec();
      for (int i = n; i < N; i++) a[i*W +: W] = t[i*W +: W];
      drive(a, b, n, 1'b0, "R4 tail");
      a[N*W-1 -: W] = ~a[N*W-1 -: W];
      drive(a, b, 7, 1'b0, "R4 elem7");
    end
    // R5: one-cycle latency on a toggling pattern, then a held input
    for (int k = 0; k < 6; k++) begin
      drive(rnd_vec(), rnd_vec(), 7 - k, 1'b0, "R5 latency");
    end
    drive(a, b, 6, 1'b0, "R5 hold");
    drive(a, b, 6, 1'b0, "R5 hold");
    // R6: reset mid-run with busy inputs
    drive({N*W{1'b1}}, {N*W{1'b1}}, 7, 1'b1, "R6 sync clear");
    drive({N*W{1'b1}}, {N*W{1'b1}}, 7, 1'b0, "R6 release");

    @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule